// File: doc/BRIEF.md
# Dual-Clock Queue With Selectable Fall-Through

This block is a first-in first-out queue for words that are 36 bits wide by default. A producer writes in one clock domain and a consumer reads in another, unrelated one. The storage depth is a parameter; 256, 512 and 1024 are the intended values. The write and read positions cross between the domains as Gray-coded counts, one bit wider than the address, through a chain of at least two flip-flops in the receiving domain.

A static mode input selects how the read side behaves. In standard mode the read-side flag means "queue not empty", and a word reaches the output register only when the consumer asks for it with a read. In fall-through mode the same flag means "output word valid": the oldest word is moved into the output register without being asked for, and a read consumes it and fetches the next one. The write side shows whether a write will be taken. Each side also has an early-warning level flag, and each flag's offset is a parameter. The mode may change only while the read side is held in reset.

Top module: `xclk_queue`

## Requirements
- R1: The position counts exchanged between the domains are Gray coded. Each published count, and each count at the output of its synchronizer, changes by at most one bit per edge of the receiving clock. Each crossing passes through at least two flip-flops.
- R2: `wr_ready` is low exactly when the write side sees DEPTH words stored. If the queue starts empty and no reads happen, it is still high after DEPTH-1 accepted writes and goes low right after the write edge of the DEPTH-th write.
- R3: A write presented while `wr_ready` is low is dropped. Reading the queue out afterwards returns exactly the DEPTH accepted words in write order, and then `rd_flag` is low.
- R4: Standard mode (`fwft_mode`=0): after a word is written into an empty queue, `rd_flag` (1 = not empty) rises on the second rising edge of the read clock that follows the write edge, and not before.
- R5: Standard mode: `rd_data` changes only on a read edge that finds data. No word is ever loaded into `rd_data` without `rd_en`.
- R6: Fall-through mode (`fwft_mode`=1): `rd_flag` means the output word is valid. When it is low, the next word written is loaded into `rd_data` on the same read edge that raises `rd_flag`. That edge is the third read edge after the write edge: two synchronizer stages, then the load.
- R7: Fall-through mode with `rd_flag` high: `rd_data` holds its word until a read. Each read replaces it with the next stored word. When the last word is consumed, `rd_flag` falls.
- R8: A read when no data is available (`rd_flag` low) is ignored in both modes. `rd_data` keeps its value, and a word written later is delivered normally.
- R9: `rd_almost_empty` is high when the read-side count is at most AE_OFS. In fall-through mode that count includes a valid output word.
- R10: `wr_almost_full` is high when the write-side count is at least DEPTH-AF_OFS.
- R11: After reset, `rd_flag`=0, `rd_almost_empty`=1, `wr_ready`=1, `wr_almost_full`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| wr_ready | output | 1 | 1 = a write will be accepted (queue not full) |
| wr_almost_full | output | 1 | Write-side count at or above DEPTH-AF_OFS |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side synchronous reset, active low |
| fwft_mode | input | 1 | 0 = standard, 1 = fall-through; change only in reset |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Output register |
| rd_flag | output | 1 | Standard: not empty; fall-through: output word valid |
| rd_almost_empty | output | 1 | Read-side count at or below AE_OFS |

## Verification
The assertions assume that `fwft_mode` holds steady whenever the read side is out of reset. They also assume that reset is held for at least two cycles, so that every synchronizer stage and every `$past` value is defined. The bench changes the mode only inside its reset task, which holds both resets for three cycles. It drives both domains from one 50 MHz clock, so that the synchronizer latencies in R4 and R6 can be checked to the exact edge.

// File: rtl/xq_pkg.sv
`timescale 1ns/1ps
// Package: shared types and constants for the dual-clock queue.
// Assumes: nothing beyond IEEE 1800-2017.
package xq_pkg;
    // Read-side behaviour selected by the mode input.
    typedef enum logic {
        XQ_STANDARD = 1'b0,
        XQ_FALLTHRU = 1'b1
    } xq_mode_e;

    // Minimum number of flip-flops on every clock-domain crossing.
    localparam int XQ_SYNC_STAGES = 2;
endpackage

// File: rtl/xq_sync.sv
`timescale 1ns/1ps
// Module: multi-stage synchronizer for a Gray-coded count.
// Assumes: the input changes by at most one bit between edges of clk,
// so every stage holds either the old or the new count.
module xq_sync #(
    parameter int W      = 9,
    parameter int STAGES = xq_pkg::XQ_SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    // Shift the foreign count through the chain of flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage[s] <= '0;
        end else begin
            stage[0] <= d;
            for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];

    // The count seen in this domain moves by at most one bit per edge.
    assert_sync_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q ^ $past(q)) <= 1);
endmodule

// File: rtl/xq_gray2bin.sv
`timescale 1ns/1ps
// Module: combinational Gray-to-binary converter.
// Assumes: nothing; pure logic of width W.
module xq_gray2bin #(
    parameter int W = 9
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    // Each binary bit is the parity of the Gray bits at and above it.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bin[i] = ^gray[W-1:i];
    end
endmodule

// File: rtl/xq_ram.sv
`timescale 1ns/1ps
// Module: storage array with a write port on the write clock and an
// asynchronous read port, which the read side registers.
// Assumes: the read side never addresses a cell that is being written,
// which the full and empty logic guarantees.
module xq_ram #(
    parameter int WIDTH = 36,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             wr_clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cells [DEPTH];

    // Store an accepted word.
    always_ff @(posedge wr_clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/xq_wr_side.sv
`timescale 1ns/1ps
// Module: write-domain control. It keeps the write count, publishes it
// in Gray code, detects full against the synchronized read count and
// produces the almost-full level.
// Assumes: rgray_s is the read count already synchronized to wr_clk.
module xq_wr_side #(
    parameter int DEPTH  = 256,
    parameter int AF_OFS = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] rgray_s,
    output logic          wr_accept,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic          wr_ready,
    output logic          wr_almost_full
);
    localparam logic [PW-1:0] AF_LEVEL = PW'(DEPTH - AF_OFS);
    localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

    logic [PW-1:0] wbin, wbin_nxt, rbin_s, wocc;
    logic          full;

    xq_gray2bin #(.W(PW)) u_rconv (.gray(rgray_s), .bin(rbin_s));

    // Full: the two top Gray bits differ from the read count, the rest match.
    assign full      = (wgray == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
    assign wr_ready  = !full;
    assign wr_accept = wr_en && !full;
    assign wbin_nxt  = wbin + PW'(1);
    assign waddr     = wbin[AW-1:0];
    assign wocc      = wbin - rbin_s;
    assign wr_almost_full = (wocc >= AF_LEVEL);

    // Advance the binary and Gray write counts on an accepted write.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_accept) begin
            wbin  <= wbin_nxt;
            wgray <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    assert_gray_step_R1: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);
    assert_full_level_R2: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !wr_ready |-> (wocc == FULL_LVL));
    assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wocc <= FULL_LVL);
    assert_drop_when_full_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && !wr_ready) |=> $stable(wgray));
endmodule

// File: rtl/xq_rd_side.sv
`timescale 1ns/1ps
// Module: read-domain control. It keeps the read count, publishes it in
// Gray code, owns the output register and its valid bit, and produces
// the dual-meaning read flag and the almost-empty level.
// Assumes: wgray_s is the write count already synchronized to rd_clk, and
// fwft_mode changes only while rd_rst_n is low.
module xq_rd_side
    import xq_pkg::*;
#(
    parameter int WIDTH  = 36,
    parameter int DEPTH  = 256,
    parameter int AE_OFS = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic             fwft_mode,
    input  logic             rd_en,
    input  logic [PW-1:0]    wgray_s,
    input  logic [WIDTH-1:0] mem_rdata,
    output logic [AW-1:0]    raddr,
    output logic [PW-1:0]    rgray,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_flag,
    output logic             rd_almost_empty
);
    localparam logic [PW-1:0] AE_LEVEL = PW'(AE_OFS);
    localparam logic [PW-1:0] MEM_MAX  = PW'(DEPTH);

    xq_mode_e      mode;
    logic          fallthru, has_mem, ovalid, pop;
    logic [PW-1:0] rbin, rbin_nxt, wbin_s, avail, rocc;

    xq_gray2bin #(.W(PW)) u_wconv (.gray(wgray_s), .bin(wbin_s));

    assign mode     = xq_mode_e'(fwft_mode);
    assign fallthru = (mode == XQ_FALLTHRU);
    assign avail    = wbin_s - rbin;
    assign has_mem  = (avail != '0);
    assign rbin_nxt = rbin + PW'(1);
    assign raddr    = rbin[AW-1:0];

    // Fetch from storage: on demand in standard mode, and also whenever the
    // output register is empty in fall-through mode.
    always_comb begin
        if (fallthru) pop = has_mem && (!ovalid || rd_en);
        else          pop = has_mem && rd_en;
    end

    // Advance the read count and load the output register on a fetch.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rbin    <= '0;
            rgray   <= '0;
            rd_data <= '0;
        end else if (pop) begin
            rbin    <= rbin_nxt;
            rgray   <= rbin_nxt ^ (rbin_nxt >> 1);
            rd_data <= mem_rdata;
        end
    end

    // Track whether the output register holds an unread word (fall-through only).
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n || !fallthru) ovalid <= 1'b0;
        else if (pop)               ovalid <= 1'b1;
        else if (rd_en)             ovalid <= 1'b0;
    end

    assign rd_flag         = fallthru ? ovalid : has_mem;
    assign rocc            = avail + PW'(fallthru && ovalid);
    assign rd_almost_empty = (rocc <= AE_LEVEL);

    assert_gray_step_R1: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);
    assert_mode_static_R6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $stable(fwft_mode));
    assert_std_no_autoload_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!fwft_mode && !rd_en) |=> $stable(rd_data));
    assert_ft_load_source_R6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (fwft_mode && $rose(rd_flag)) |-> $past(has_mem));
    assert_ft_hold_R7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (fwft_mode && rd_flag && !rd_en) |=> (rd_flag && $stable(rd_data)));
    assert_no_underflow_R8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        avail <= MEM_MAX);
endmodule

// File: rtl/xclk_queue.sv
`timescale 1ns/1ps
// Module: top of the dual-clock queue. It ties together the storage, the
// two domain controllers and the two count synchronizers.
// Assumes: DEPTH is a power of two of at least 4; the two clocks may be
// unrelated; each reset is synchronous to its own clock.
module xclk_queue #(
    parameter int WIDTH  = 36,
    parameter int DEPTH  = 256,
    parameter int AE_OFS = 4,
    parameter int AF_OFS = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_ready,
    output logic             wr_almost_full,
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic             fwft_mode,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_flag,
    output logic             rd_almost_empty
);
    logic             wr_accept;
    logic [AW-1:0]    waddr, raddr;
    logic [PW-1:0]    wgray, rgray, wgray_rs, rgray_ws;
    logic [WIDTH-1:0] mem_rdata;

    xq_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .wr_clk (wr_clk),
        .we     (wr_accept),
        .waddr  (waddr),
        .wdata  (wr_data),
        .raddr  (raddr),
        .rdata  (mem_rdata)
    );

    xq_wr_side #(.DEPTH(DEPTH), .AF_OFS(AF_OFS)) u_wr (
        .wr_clk         (wr_clk),
        .wr_rst_n       (wr_rst_n),
        .wr_en          (wr_en),
        .rgray_s        (rgray_ws),
        .wr_accept      (wr_accept),
        .waddr          (waddr),
        .wgray          (wgray),
        .wr_ready       (wr_ready),
        .wr_almost_full (wr_almost_full)
    );

    xq_sync #(.W(PW)) u_w2r (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wgray),
        .q     (wgray_rs)
    );

    xq_sync #(.W(PW)) u_r2w (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (rgray),
        .q     (rgray_ws)
    );

    xq_rd_side #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AE_OFS(AE_OFS)) u_rd (
        .rd_clk          (rd_clk),
        .rd_rst_n        (rd_rst_n),
        .fwft_mode       (fwft_mode),
        .rd_en           (rd_en),
        .wgray_s         (wgray_rs),
        .mem_rdata       (mem_rdata),
        .raddr           (raddr),
        .rgray           (rgray),
        .rd_data         (rd_data),
        .rd_flag         (rd_flag),
        .rd_almost_empty (rd_almost_empty)
    );
endmodule

// File: tb/xclk_queue_test.sv
`timescale 1ns/1ps
// Directed bench: both domains share one 50 MHz clock so that latencies are exact.
module xclk_queue_test;
    localparam int W      = 36;
    localparam int DEPTH  = 256;
    localparam int AE_OFS = 4;
    localparam int AF_OFS = 4;
    localparam int AF_LVL = DEPTH - AF_OFS;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         wr_ready, wr_almost_full;
    logic         fwft_mode = 1'b0;
    logic         rd_en = 1'b0;
    logic [W-1:0] rd_data;
    logic         rd_flag, rd_almost_empty;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    xclk_queue #(.WIDTH(W), .DEPTH(DEPTH), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS)) uut (
        .wr_clk          (clk),
        .wr_rst_n        (rst_n),
        .wr_en           (wr_en),
        .wr_data         (wr_data),
        .wr_ready        (wr_ready),
        .wr_almost_full  (wr_almost_full),
        .rd_clk          (clk),
        .rd_rst_n        (rst_n),
        .fwft_mode       (fwft_mode),
        .rd_en           (rd_en),
        .rd_data         (rd_data),
        .rd_flag         (rd_flag),
        .rd_almost_empty (rd_almost_empty)
    );

    function automatic logic [W-1:0] mk(int i);
        return {4'h5, 32'(i)};
    endfunction

    task automatic chk(string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic do_reset(logic mode);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; fwft_mode = mode;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // One write; returns at the negedge just after the write edge.
    task automatic push(logic [W-1:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // One read; returns at the negedge just after the read edge.
    task automatic pull();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset(1'b0);
        idle(1);
        chk("R11 rd_flag",         W'(rd_flag),         W'(0));
        chk("R11 rd_almost_empty", W'(rd_almost_empty), W'(1));
        chk("R11 wr_ready",        W'(wr_ready),        W'(1));
        chk("R11 wr_almost_full",  W'(wr_almost_full),  W'(0));
        chk("R11 rd_data",         rd_data,             W'(0));
    endtask

    task automatic t_std_latency();
        do_reset(1'b0);
        push(mk(77));
        chk("R4 flag low after write edge", W'(rd_flag), W'(0));
        idle(1);
        chk("R4 flag low after first read edge", W'(rd_flag), W'(0));
        idle(1);
        chk("R4 flag high after second read edge", W'(rd_flag), W'(1));
        idle(4);
        chk("R5 no autoload in standard mode", rd_data, W'(0));
        pull();
        chk("R5 explicit read delivers word", rd_data, mk(77));
        chk("R4 flag low after last word read", W'(rd_flag), W'(0));
        pull();
        chk("R8 read on empty keeps rd_data", rd_data, mk(77));
        push(mk(78));
        idle(3);
        pull();
        chk("R8 later word delivered after empty read", rd_data, mk(78));
    endtask

    task automatic t_std_almost_empty();
        do_reset(1'b0);
        for (int i = 0; i < AE_OFS + 1; i++) push(mk(200 + i));
        idle(3);
        chk("R9 std almost_empty low above offset", W'(rd_almost_empty), W'(0));
        pull();
        chk("R9 std almost_empty high at offset", W'(rd_almost_empty), W'(1));
    endtask

    task automatic t_fill_drain();
        do_reset(1'b0);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            if (i == AF_LVL - 1) chk("R10 almost_full low one below level", W'(wr_almost_full), W'(0));
            if (i == AF_LVL)     chk("R10 almost_full high at level", W'(wr_almost_full), W'(1));
            if (i == DEPTH - 1)  chk("R2 wr_ready high with DEPTH-1 stored", W'(wr_ready), W'(1));
            wr_en = 1'b1; wr_data = mk(16'h1000 + i);
        end
        @(negedge clk);
        chk("R2 wr_ready low after DEPTH-th write", W'(wr_ready), W'(0));
        wr_data = {4'hF, 32'hDEAD_BEEF};
        idle(3);
        wr_en = 1'b0;
        chk("R3 wr_ready stays low after dropped writes", W'(wr_ready), W'(0));
        idle(4);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            if (i > 0) chk("R3 drained word order", rd_data, mk(16'h1000 + i - 1));
            rd_en = 1'b1;
        end
        @(negedge clk);
        rd_en = 1'b0;
        chk("R3 last drained word", rd_data, mk(16'h1000 + DEPTH - 1));
        chk("R3 no extra word after drain", W'(rd_flag), W'(0));
    endtask

    task automatic t_ft_flow();
        do_reset(1'b1);
        push(mk(1));
        idle(1);
        chk("R6 flag low after first read edge", W'(rd_flag), W'(0));
        idle(1);
        chk("R6 flag low after second read edge", W'(rd_flag), W'(0));
        idle(1);
        chk("R6 flag high after third read edge", W'(rd_flag), W'(1));
        chk("R6 word loaded on same edge", rd_data, mk(1));
        push(mk(2));
        push(mk(3));
        idle(5);
        chk("R7 head word held without read", rd_data, mk(1));
        pull();
        chk("R7 read advances to second word", rd_data, mk(2));
        pull();
        chk("R7 read advances to third word", rd_data, mk(3));
        chk("R7 flag still high with third word", W'(rd_flag), W'(1));
        pull();
        chk("R7 flag falls after last word consumed", W'(rd_flag), W'(0));
        pull();
        chk("R8 read on empty keeps output word", rd_data, mk(3));
        push(mk(4));
        idle(3);
        chk("R8 later word falls through normally", rd_data, mk(4));
        chk("R8 flag high for later word", W'(rd_flag), W'(1));
    endtask

    task automatic t_ft_almost_empty();
        do_reset(1'b1);
        for (int i = 0; i < AE_OFS + 1; i++) push(mk(300 + i));
        idle(4);
        chk("R9 fall-through count includes output word", W'(rd_almost_empty), W'(0));
        pull();
        chk("R9 fall-through almost_empty high at offset", W'(rd_almost_empty), W'(1));
    endtask

    initial begin
        t_reset_state();
        t_std_latency();
        t_std_almost_empty();
        t_fill_drain();
        t_ft_flow();
        t_ft_almost_empty();
        // R1 is covered by the Gray-step assertions throughout all scenarios.
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule